// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a simple internal request port and an external asynchronous static RAM with an 18-bit word address, a 16-bit data bus, active-low chip, write and output enables, and one active-low enable per byte lane. A requester presents a read/write flag, an address, write data and a two-bit lane mask under a valid/ready handshake. For reads it gets back the data with a one-cycle valid strobe.

All memory timing minimums are entered as nanosecond parameters together with the clock period. The controller rounds each one up to whole cycles and uses the result to size the phases of each access: address and enables, then strobe, then release, then for reads a bus-quiet interval. It also drives the enable of the external tri-state data driver. The driver is enabled only while the memory's outputs are held off, so the two never drive the bus together.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst` is high, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both `mem_be_n` bits are 1, `dq_oe` and `rsp_valid` are 0 and `req_ready` is 0. `req_ready` becomes 1 on the first clock edge after `rst` falls.
- R2: A write with a non-zero mask drives `dq_oe`=1 with `dq_out`=write data, and holds `mem_oe_n`=1. It pulls `mem_ce_n` and `mem_we_n` low together, with `mem_be_n[0]` low exactly when mask bit 0 is 1 (data bits 7:0) and `mem_be_n[1]` low exactly when mask bit 1 is 1 (bits 15:8). Only the enabled lanes of the addressed word change.
- R3: `mem_we_n` stays low for exactly WRS cycles, where WRS is the largest of ceil(tWP/T), ceil(tSD/T), ceil(tAW/T)-1 and ceil(tWC/T)-2. `mem_ce_n` stays low for WRS+1 cycles, so that with the release cycle the write cycle covers tWC.
- R4: A read with a non-zero mask holds `mem_we_n`=1 and `mem_ce_n`=`mem_oe_n`=0 for RDS+1 cycles, where RDS = max(1, ceil(tAA/T)-1, ceil(tDOE/T)-1). The data is sampled on the edge that ends that window. `rsp_valid` is 1 for the following single cycle, with the sample in `rsp_rdata`.
- R5: In a read response, each lane whose mask bit is 0 returns zero, whatever the bus carries on it.
- R6: A request with mask 00 starts no bus cycle (`mem_ce_n` stays 1) and leaves `req_ready` at 1. A zero-mask write changes nothing. A zero-mask read returns `rsp_valid`=1 with `rsp_rdata`=0 in the next cycle.
- R7: `dq_oe` is never 1 in a cycle where `mem_oe_n` is 0, and `mem_we_n` and `mem_oe_n` are never low together.
- R8: After a read, `dq_oe` stays 0 for at least TRN+1 cycles after `mem_oe_n` rises, where TRN = max(1, ceil(tHZOE/T)).
- R9: `mem_addr` is stable while `mem_ce_n` is low, and `dq_out` is stable while `mem_we_n` is low.
- R10: From the accept of a non-zero-mask request until the controller is idle again, `req_ready` is 0, and `mem_ce_n` is never low while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| dq_out | output | 16 | Data toward the bus driver |
| dq_oe | output | 1 | Bus driver enable |
| dq_in | input | 16 | Data from the bus |

## Verification
Writes are issued with each of the three non-zero masks to the same and to different addresses, including the lowest and highest word. Reading back with full and partial masks then shows whether the lane enables select the right byte and whether disabled lanes read as zero. The bench memory returns a fixed filler on lanes the controller did not enable, so a missing mask on capture is seen as a wrong byte rather than a coincident zero. Zero-mask reads and writes tell a true no-op apart from a bus cycle with all lanes off. A write placed right after a read measures the quiet gap on the bus, and back-to-back accesses check the measured strobe widths against the rounded timing.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_t;

  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WR_CYC   = 4,
  parameter int RD_CYC   = 5,
  parameter int TURN_CYC = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   go,
  input  logic   go_rd,
  output phase_t phase_q,
  output phase_t phase_d,
  output logic   rd_q,
  output logic   rd_d,
  output logic   strobe_end
);

  localparam int MAXC = imax(imax(WR_CYC, RD_CYC), TURN_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign rd_d       = go ? go_rd : rd_q;
  assign strobe_end = (phase_q == PH_STROBE) && (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    case (phase_q)
      PH_IDLE:   if (go) phase_d = PH_SETUP;
      PH_SETUP: begin
        phase_d = PH_STROBE;
        cnt_d   = rd_q ? CW'(RD_CYC - 1) : CW'(WR_CYC - 1);
      end
      PH_STROBE: if (cnt_q == '0) phase_d = PH_HOLD;
      PH_HOLD: begin
        if (rd_q) begin
          phase_d = PH_TURN;
          cnt_d   = CW'(TURN_CYC - 1);
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_TURN:   if (cnt_q == '0) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
    end
  end

  // a new access only ever starts from idle
  assert_go_from_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |-> !go);

  // after a read strobe the bus-quiet phase always follows the release phase
  assert_turn_after_read_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD && rd_q) |=> (phase_q == PH_TURN));

endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] wbyte_in,
  input  logic          act_d,
  input  logic          en_d,
  input  logic          en_q,
  input  logic          cap,
  input  logic          clr,
  input  logic [LW-1:0] bus_in,
  output logic [LW-1:0] wbyte_q,
  output logic [LW-1:0] rbyte_q,
  output logic          be_n_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbyte_q <= '0;
      rbyte_q <= '0;
      be_n_q  <= 1'b1;
    end else begin
      if (load) wbyte_q <= wbyte_in;
      be_n_q <= !(act_d && en_d);
      if (clr)      rbyte_q <= '0;
      else if (cap) rbyte_q <= en_q ? bus_in : '0;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int T_WP_NS   = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_AW_NS   = 40,
  parameter int T_WC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_HZOE_NS = 20,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int WR_CYC = imax(imax(cyc_ceil(T_WP_NS, CLK_NS), cyc_ceil(T_SD_NS, CLK_NS)),
                               imax(cyc_ceil(T_AW_NS, CLK_NS) - 1, cyc_ceil(T_WC_NS, CLK_NS) - 2));
  localparam int RD_CYC = imax(1, imax(cyc_ceil(T_AA_NS, CLK_NS) - 1,
                                       cyc_ceil(T_DOE_NS, CLK_NS) - 1));
  localparam int TURN_CYC = imax(1, cyc_ceil(T_HZOE_NS, CLK_NS));

  phase_t phase_q, phase_d;
  logic   rd_q, rd_d, strobe_end;
  logic   accept, go, zero_rd, act_d;
  logic   ready_q, rsp_valid_q, ce_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q, mask_d;

  assign accept  = req_valid && ready_q;
  assign go      = accept && (|req_mask);
  assign zero_rd = accept && req_rd && !(|req_mask);
  assign mask_d  = go ? req_mask : mask_q;
  assign act_d   = (phase_d == PH_SETUP) || (phase_d == PH_STROBE);

  sram_seq #(
    .WR_CYC   (WR_CYC),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .go_rd      (req_rd),
    .phase_q    (phase_q),
    .phase_d    (phase_d),
    .rd_q       (rd_q),
    .rd_d       (rd_d),
    .strobe_end (strobe_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      ce_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      dq_oe_q     <= 1'b0;
      addr_q      <= '0;
      mask_q      <= '0;
    end else begin
      ready_q     <= (phase_d == PH_IDLE);
      rsp_valid_q <= zero_rd || (strobe_end && rd_q);
      ce_n_q      <= !act_d;
      we_n_q      <= !((phase_d == PH_STROBE) && !rd_d);
      oe_n_q      <= !(act_d && rd_d);
      dq_oe_q     <= (act_d || (phase_d == PH_HOLD)) && !rd_d;
      mask_q      <= mask_d;
      if (go) addr_q <= req_addr;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_lane #(.LW(8)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (go),
      .wbyte_in (req_wdata[8*i +: 8]),
      .act_d    (act_d),
      .en_d     (mask_d[i]),
      .en_q     (mask_q[i]),
      .cap      (strobe_end && rd_q),
      .clr      (zero_rd),
      .bus_in   (dq_in[8*i +: 8]),
      .wbyte_q  (dq_out[8*i +: 8]),
      .rbyte_q  (rsp_rdata[8*i +: 8]),
      .be_n_q   (mem_be_n[i])
    );
  end

  assign req_ready = ready_q;
  assign rsp_valid = rsp_valid_q;
  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;
  assign dq_oe     = dq_oe_q;

  // ---------------- checks next to the sequencing logic ----------------
  logic [15:0] we_run_q;
  always_ff @(posedge clk) begin
    if (rst)            we_run_q <= '0;
    else if (!mem_we_n) we_run_q <= (we_run_q == 16'hFFFF) ? we_run_q : we_run_q + 1'b1;
    else                we_run_q <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (mem_ce_n && mem_we_n && mem_oe_n && !dq_oe && !req_ready && !rsp_valid));

  assert_we_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run_q == 16'(WR_CYC)));

  assert_write_framed_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && dq_oe && !(&mem_be_n)));

  assert_no_fight_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !dq_oe);

  assert_we_oe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_wdata_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(dq_out));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready);

  assert_zero_mask_noop_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && !(|req_mask)) |=> (mem_ce_n && req_ready));

endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

  localparam int CLK = 8;
  function automatic int cl(input int ns);
    return (ns + CLK - 1) / CLK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int WRS = mx(mx(cl(40), cl(25)), mx(cl(40) - 1, cl(55) - 2));
  localparam int RDS = mx(1, mx(cl(55) - 1, cl(25) - 1));
  localparam int TRN = mx(1, cl(20));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_rd = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, dq_oe;
  logic [15:0] rsp_rdata, dq_out;
  logic [15:0] dq_in = 16'hA5A5;
  logic [17:0] mem_addr;
  logic [1:0]  mem_be_n;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model fed by the pins, and reference model fed by the driver
  logic [15:0] pin_mem [int];
  logic [15:0] ref_mem [int];
  logic [15:0] exp_q [$];

  int we_run = 0, oe_run = 0, ce_run = 0, gap = -1, ce_falls = 0;
  int fight_vio = 0, stab_vio = 0;
  logic [17:0] last_addr;
  bit prev_ce_n = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      // write into pin memory while write window is open
      if (!mem_ce_n && !mem_we_n) begin
        logic [15:0] w;
        w = pin_mem.exists(int'(mem_addr)) ? pin_mem[int'(mem_addr)] : 16'h0;
        if (!mem_be_n[0]) w[7:0]  = dq_out[7:0];
        if (!mem_be_n[1]) w[15:8] = dq_out[15:8];
        pin_mem[int'(mem_addr)] = w;
      end
      if (dq_oe && !mem_oe_n) fight_vio++;
      if (!mem_ce_n && !prev_ce_n && mem_addr != last_addr) stab_vio++;
      if (!mem_ce_n && prev_ce_n) ce_falls++;
      prev_ce_n = mem_ce_n;
      last_addr = mem_addr;
      // strobe widths
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin
        chk(we_run == WRS, "R3 we width", we_run, WRS);
        we_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin
        chk(oe_run == RDS + 1, "R4 oe window", oe_run, RDS + 1);
        oe_run = 0;
        gap = 0;
      end
      if (!mem_ce_n && mem_oe_n && mem_we_n) ce_run++;
      if (!mem_ce_n) ce_run++;
      else if (ce_run != 0) ce_run = 0;
      if (gap >= 0) begin
        if (dq_oe) begin
          chk(gap >= TRN + 1, "R8 turnaround gap", gap, TRN + 1);
          gap = -1;
        end else gap++;
      end
      // response monitor
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected response", rsp_rdata, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R5 read data", rsp_rdata, e);
        end
      end
      // bus model: drive stored data on enabled lanes, filler elsewhere
      begin
        logic [15:0] r;
        r = pin_mem.exists(int'(mem_addr)) ? pin_mem[int'(mem_addr)] : 16'h0;
        dq_in[7:0]  <= (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[0]) ? r[7:0]  : 8'hA5;
        dq_in[15:8] <= (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[1]) ? r[15:8] : 8'hA5;
      end
    end
  end

  task automatic issue(input bit rd, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, input string tag);
    int falls0;
    logic [15:0] cur;
    cur = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
    if (rd) exp_q.push_back(cur & {{8{m[1]}}, {8{m[0]}}});
    else begin
      if (m[0]) cur[7:0]  = d[7:0];
      if (m[1]) cur[15:8] = d[15:8];
      ref_mem[int'(a)] = cur;
    end
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    falls0 = ce_falls;
    @(negedge clk);
    req_valid = 1'b0;
    if (m == 2'b00) begin
      chk(req_ready == 1'b1, {"R6 ready kept ", tag}, req_ready, 1);
      repeat (3) @(negedge clk);
      chk(ce_falls == falls0, {"R6 no bus cycle ", tag}, ce_falls - falls0, 0);
    end else begin
      chk(req_ready == 1'b0, {"R10 busy ", tag}, req_ready, 0);
    end
  endtask

  task automatic wait_idle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n), "R1 strobes in reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'h1F);
    chk(!dq_oe && !req_ready && !rsp_valid, "R1 driver/ready in reset",
        {dq_oe, req_ready, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    issue(0, 18'h00000, 16'h1234, 2'b11, "R2 full write");
    issue(0, 18'h3FFFF, 16'hBEEF, 2'b11, "R2 top write");
    issue(0, 18'h00010, 16'hAAAA, 2'b11, "R2 base");
    issue(0, 18'h00010, 16'h5566, 2'b01, "R2 low lane");
    issue(0, 18'h00020, 16'hCAFE, 2'b11, "R2 base2");
    issue(0, 18'h00020, 16'h7788, 2'b10, "R2 high lane");
    issue(1, 18'h00000, 16'h0, 2'b11, "R4 read full");
    issue(1, 18'h3FFFF, 16'h0, 2'b11, "R4 read top");
    issue(1, 18'h00010, 16'h0, 2'b11, "R2 read low-lane merge");
    issue(1, 18'h00020, 16'h0, 2'b11, "R2 read high-lane merge");
    issue(1, 18'h00010, 16'h0, 2'b01, "R5 read low only");
    issue(1, 18'h00020, 16'h0, 2'b10, "R5 read high only");
    issue(0, 18'h00000, 16'hFFFF, 2'b00, "R6 zero write");
    issue(1, 18'h00000, 16'h0, 2'b00, "R6 zero read");
    issue(1, 18'h00000, 16'h0, 2'b11, "R6 unchanged");
    // read directly followed by write exercises the bus-quiet gap
    issue(1, 18'h3FFFF, 16'h0, 2'b01, "R8 read");
    issue(0, 18'h00040, 16'h0F0F, 2'b11, "R8 write after read");
    issue(1, 18'h00040, 16'h0, 2'b11, "R8 readback");
    wait_idle();
    chk(exp_q.size() == 0, "R4 all responses seen", exp_q.size(), 0);
    chk(fight_vio == 0, "R7 no bus fight", fight_vio, 0);
    chk(stab_vio == 0, "R9 address stable", stab_vio, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule